// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the per-input state of a bank of interrupt sources and decides when each one is offered to a presentation unit. Its inputs are numbered from a fixed base. Each input is either level-sensitive or message (edge) type; the type is fixed by a parameter mask. Each input carries a routing entry: a target server, an active priority and a saved priority. A priority of 0xFF masks the input.

Once an input qualifies, it gets a pending offer bit. The presentation port shows the lowest-numbered pending offer together with the current server and priority of that input, and it consumes the offer on a valid/ready handshake. The presentation unit reports back in three ways: it can reject an interrupt number, signal end-of-interrupt for a number, or request that every input be re-offered. That last request starts a sequential scan that re-applies the presentation rules. A configuration port writes or reads the routing entry, and it can disable (mask) or enable (restore) an input.

Top module: `irq_source_ctl`

## Requirements
- R1: After reset, no offer is pending and no scan is running. Every input reads back server 0 and priority 0xFF, and all status bits are clear.
- R2: A configuration request gets `cfg_err` and changes nothing in these cases:
  - its number lies outside [BASE, BASE+N);
  - it is a write whose priority exceeds 255;
  - it is a write whose server is not below NUM_SRV.
- R3: Every configuration request is acknowledged one cycle later on `cfg_ack`. The op codes are 0 write, 1 read, 2 disable and 3 enable. A write sets the server, the priority and the saved priority. A read returns the server and the priority held at request time.
- R4: A rising edge on an unmasked message input produces an offer of its number, server and priority.
- R5: A rising edge on a masked message input is remembered as masked-pending. A later configuration that leaves the priority below 0xFF clears masked-pending and produces an offer.
- R6: A level input is offered only when three things hold: it is unmasked, its line is asserted, and it is not yet sent. Being offered sets sent. The rule is applied when the line changes, on a configuration of that input, and during the scan.
- R7: A reject for a valid number sets that input's rejected bit and clears its sent bit.
- R8: An end-of-interrupt clears sent for a level input. It does not offer anything by itself, and it has no effect on message inputs.
- R9: During a scan:
  - each level input applies the R6 rule;
  - each rejected message input has its rejected bit cleared and is re-offered only if unmasked.
- R10: Disable copies the priority into the saved priority and sets the priority to 0xFF. Enable copies the saved priority back into the priority.
- R11: A resend request starts a scan that visits one input per cycle in index order. The scan stalls while an offer is shown. `resend_busy` stays high from the cycle after the request until the last input has been visited.
- R12: When a configuration write and an input edge hit the same input in one cycle, the write is applied first, and the edge is judged against the new priority.
- R13: When several offers are pending, the lowest number is shown first. An offer is held until `pres_ready`, and a shown offer never carries priority 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | N | Interrupt lines, one per input |
| cfg_valid | input | 1 | Configuration request strobe |
| cfg_op | input | 2 | 0 write, 1 read, 2 disable, 3 enable |
| cfg_num | input | NUM_W | Interrupt number addressed |
| cfg_srv | input | SRV_W | Server for a write |
| cfg_prio | input | 9 | Priority for a write (values above 255 are rejected) |
| cfg_ack | output | 1 | Response valid, one cycle after the request |
| cfg_err | output | 1 | Request refused |
| cfg_rd_srv | output | SRV_W | Server read back |
| cfg_rd_prio | output | 8 | Priority read back |
| pres_valid | output | 1 | An offer is shown |
| pres_num | output | NUM_W | Number of the shown offer |
| pres_srv | output | SRV_W | Server of the shown offer |
| pres_prio | output | 8 | Priority of the shown offer |
| pres_ready | input | 1 | Presentation unit takes the shown offer |
| rej_valid | input | 1 | Reject strobe |
| rej_num | input | NUM_W | Number rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Number completed |
| resend_req | input | 1 | Request to re-offer all inputs |
| resend_busy | output | 1 | Resend scan in progress |

## Verification
Every strobe, edge and configuration request is registered on one rising edge. Its result appears one cycle later: the configuration response, the new offer on the presentation port, and the busy flag after a resend request. The bench drives inputs on the falling edge and samples on the next falling edge. Scan results depend on the scan position, so the bench counts cycles from the request. It expects the first offer two edges after the scan reaches that input's index, and it counts the stalled cycles separately. For each expected offer it also checks the cycles just before that offer is due.

// File: rtl/irq_source_ctl.sv
module irq_source_ctl #(
  parameter int N = 8,
  parameter int BASE = 16,
  parameter int NUM_W = 12,
  parameter int SRV_W = 3,
  parameter int NUM_SRV = 4,
  parameter logic [N-1:0] LEVEL_MASK = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     src_in,
  input  logic             cfg_valid,
  input  logic [1:0]       cfg_op,
  input  logic [NUM_W-1:0] cfg_num,
  input  logic [SRV_W-1:0] cfg_srv,
  input  logic [8:0]       cfg_prio,
  output logic             cfg_ack,
  output logic             cfg_err,
  output logic [SRV_W-1:0] cfg_rd_srv,
  output logic [7:0]       cfg_rd_prio,
  output logic             pres_valid,
  output logic [NUM_W-1:0] pres_num,
  output logic [SRV_W-1:0] pres_srv,
  output logic [7:0]       pres_prio,
  input  logic             pres_ready,
  input  logic             rej_valid,
  input  logic [NUM_W-1:0] rej_num,
  input  logic             eoi_valid,
  input  logic [NUM_W-1:0] eoi_num,
  input  logic             resend_req,
  output logic             resend_busy
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [7:0] MASKED = 8'hFF;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_DIS = 2'd2;

  function automatic logic in_range(input logic [NUM_W-1:0] n);
    return (32'(n) >= 32'(BASE)) && (32'(n) < 32'(BASE + N));
  endfunction

  function automatic logic [IDX_W-1:0] to_idx(input logic [NUM_W-1:0] n);
    logic [NUM_W-1:0] d;
    d = n - NUM_W'(BASE);
    return d[IDX_W-1:0];
  endfunction

  function automatic logic lvl_fire(input logic [7:0] p, input logic a, input logic s);
    return (p != MASKED) && a && !s;
  endfunction

  logic [SRV_W-1:0] srv_v [N];
  logic [7:0]       prio_v [N];
  logic [N-1:0]     off_v;
  logic [IDX_W-1:0] sel, scan_idx;
  logic             scan_step, grant, cfg_ok;
  logic [IDX_W-1:0] cfg_idx, rej_idx, eoi_idx;

  assign cfg_idx = to_idx(cfg_num);
  assign rej_idx = to_idx(rej_num);
  assign eoi_idx = to_idx(eoi_num);
  assign cfg_ok  = in_range(cfg_num) &&
                   (cfg_op != OP_WR || (cfg_prio <= 9'd255 && 32'(cfg_srv) < 32'(NUM_SRV)));

  always_comb begin
    sel = '0;
    for (int k = N - 1; k >= 0; k--)
      if (off_v[k]) sel = IDX_W'(k);
  end

  assign pres_valid = |off_v;
  assign pres_num   = NUM_W'(BASE) + NUM_W'(sel);
  assign pres_srv   = srv_v[sel];
  assign pres_prio  = prio_v[sel];
  assign grant      = pres_valid && pres_ready;
  assign scan_step  = resend_busy && !pres_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resend_busy <= 1'b0;
      scan_idx    <= '0;
    end else if (resend_req) begin
      resend_busy <= 1'b1;
      scan_idx    <= '0;
    end else if (scan_step) begin
      if (32'(scan_idx) == N - 1) resend_busy <= 1'b0;
      else scan_idx <= scan_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_ack     <= 1'b0;
      cfg_err     <= 1'b0;
      cfg_rd_srv  <= '0;
      cfg_rd_prio <= MASKED;
    end else begin
      cfg_ack <= cfg_valid;
      cfg_err <= cfg_valid && !cfg_ok;
      if (cfg_valid && in_range(cfg_num)) begin
        cfg_rd_srv  <= srv_v[cfg_idx];
        cfg_rd_prio <= prio_v[cfg_idx];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    localparam bit LVL = LEVEL_MASK[i];
    logic [SRV_W-1:0] srv_q, srv_n;
    logic [7:0] prio_q, prio_n, sav_q, sav_n;
    logic asr_q, asr_n, sent_q, sent_n, rej_q, rej_n, mp_q, mp_n, off_q, off_n;
    logic cfg_hit, rej_hit, eoi_hit, scan_hit, take;

    assign cfg_hit  = cfg_valid && cfg_ok && cfg_op != OP_RD && cfg_idx == IDX_W'(i);
    assign rej_hit  = rej_valid && in_range(rej_num) && rej_idx == IDX_W'(i);
    assign eoi_hit  = eoi_valid && in_range(eoi_num) && eoi_idx == IDX_W'(i);
    assign scan_hit = scan_step && scan_idx == IDX_W'(i);
    assign take     = grant && sel == IDX_W'(i);

    always_comb begin
      srv_n = srv_q; prio_n = prio_q; sav_n = sav_q;
      asr_n = asr_q; sent_n = sent_q; rej_n = rej_q; mp_n = mp_q;
      off_n = off_q && !take;
      if (cfg_hit) begin
        case (cfg_op)
          OP_WR:   begin srv_n = cfg_srv; prio_n = cfg_prio[7:0]; sav_n = cfg_prio[7:0]; end
          OP_DIS:  begin sav_n = prio_q; prio_n = MASKED; end
          default: prio_n = sav_q;
        endcase
        if (prio_n == MASKED) off_n = 1'b0;
        if (LVL) begin
          if (lvl_fire(prio_n, asr_n, sent_n)) begin sent_n = 1'b1; off_n = 1'b1; end
        end else if (mp_n && prio_n != MASKED) begin
          mp_n = 1'b0; off_n = 1'b1;
        end
      end
      if (rej_hit) begin rej_n = 1'b1; sent_n = 1'b0; end
      if (eoi_hit && LVL) sent_n = 1'b0;
      if (LVL) begin
        if (src_in[i] != asr_q) begin
          asr_n = src_in[i];
          if (lvl_fire(prio_n, asr_n, sent_n)) begin sent_n = 1'b1; off_n = 1'b1; end
        end
      end else begin
        asr_n = src_in[i];
        if (src_in[i] && !asr_q) begin
          if (prio_n == MASKED) mp_n = 1'b1;
          else off_n = 1'b1;
        end
      end
      if (scan_hit) begin
        if (LVL) begin
          if (lvl_fire(prio_n, asr_n, sent_n)) begin sent_n = 1'b1; off_n = 1'b1; end
        end else if (rej_n) begin
          rej_n = 1'b0;
          if (prio_n != MASKED) off_n = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        srv_q <= '0; prio_q <= MASKED; sav_q <= MASKED;
        asr_q <= 1'b0; sent_q <= 1'b0; rej_q <= 1'b0; mp_q <= 1'b0; off_q <= 1'b0;
      end else begin
        srv_q <= srv_n; prio_q <= prio_n; sav_q <= sav_n;
        asr_q <= asr_n; sent_q <= sent_n; rej_q <= rej_n; mp_q <= mp_n; off_q <= off_n;
      end
    end

    assign srv_v[i]  = srv_q;
    assign prio_v[i] = prio_q;
    assign off_v[i]  = off_q;

    assert_reject_clears_sent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rej_hit && !cfg_hit && !scan_hit && src_in[i] == asr_q |=> !sent_q && rej_q);
    assert_masked_never_pending_R13: assert property (@(posedge clk) disable iff (!rst_n)
      off_q |-> prio_q != MASKED);
    if (!LVL) begin : g_msg
      assert_eoi_no_effect_msg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_hit && !rej_hit && !cfg_hit && !scan_hit && !(src_in[i] && !asr_q) |=> $stable(rej_q) && $stable(mp_q));
    end
  end

  assert_shown_unmasked_R13: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> pres_prio != MASKED);
  assert_ack_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> cfg_ack);
  assert_no_spurious_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |=> !cfg_ack);
  assert_bad_number_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !in_range(cfg_num) |=> cfg_err);
  assert_scan_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resend_busy && pres_valid && !resend_req |=> resend_busy && $stable(scan_idx));
endmodule

// File: tb/sim_irq_source_ctl.sv
module sim_irq_source_ctl;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [7:0]  src_in = '0;
  logic        cfg_valid = 0, pres_ready = 0, rej_valid = 0, eoi_valid = 0, resend_req = 0;
  logic [1:0]  cfg_op = '0;
  logic [11:0] cfg_num = '0, rej_num = '0, eoi_num = '0;
  logic [2:0]  cfg_srv = '0;
  logic [8:0]  cfg_prio = '0;
  logic        cfg_ack, cfg_err, pres_valid, resend_busy;
  logic [2:0]  cfg_rd_srv, pres_srv;
  logic [7:0]  cfg_rd_prio, pres_prio;
  logic [11:0] pres_num;

  irq_source_ctl u0 (.*);

  int checks = 0, fails = 0;
  logic [2:0] sh_srv [8];
  logic [7:0] sh_prio [8], sh_sav [8];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_err(input int op, input int num, input int srv, input int prio);
    return !(num >= 16 && num < 24) || (op == 0 && (prio > 255 || srv >= 4));
  endfunction

  task automatic cfg(input int op, input int num, input int srv, input int prio);
    logic e;
    int k;
    e = exp_err(op, num, srv, prio);
    k = num - 16;
    cfg_valid = 1; cfg_op = 2'(op); cfg_num = 12'(num); cfg_srv = 3'(srv); cfg_prio = 9'(prio);
    @(negedge clk);
    cfg_valid = 0;
    chk("R3 ack", 32'(cfg_ack), 1);
    chk("R2 err", 32'(cfg_err), 32'(e));
    if (!e) begin
      if (op == 1) begin
        chk("R3 read server", 32'(cfg_rd_srv), 32'(sh_srv[k]));
        chk("R3 read prio", 32'(cfg_rd_prio), 32'(sh_prio[k]));
      end else if (op == 0) begin
        sh_srv[k] = 3'(srv); sh_prio[k] = 8'(prio); sh_sav[k] = 8'(prio);
      end else if (op == 2) begin
        sh_sav[k] = sh_prio[k]; sh_prio[k] = 8'hFF;
      end else sh_prio[k] = sh_sav[k];
    end
  endtask

  task automatic pulse(input int i);
    src_in[i] = 1; @(negedge clk); src_in[i] = 0;
  endtask

  task automatic consume();
    pres_ready = 1; @(negedge clk); pres_ready = 0;
  endtask

  task automatic expect_offer(input string tag, input int num, input int srv, input int prio);
    chk({tag, " valid"}, 32'(pres_valid), 1);
    chk({tag, " num"}, 32'(pres_num), 32'(num));
    chk({tag, " srv"}, 32'(pres_srv), 32'(srv));
    chk({tag, " prio"}, 32'(pres_prio), 32'(prio));
  endtask

  task automatic strobe_rej(input int num);
    rej_valid = 1; rej_num = 12'(num); @(negedge clk); rej_valid = 0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic seen;
    for (int k = 0; k < 8; k++) begin sh_srv[k] = 0; sh_prio[k] = 8'hFF; sh_sav[k] = 8'hFF; end
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 no offer", 32'(pres_valid), 0);
    chk("R1 not busy", 32'(resend_busy), 0);
    cfg(1, 16, 0, 0);
    cfg(1, 23, 0, 0);
    // R2 refused requests
    cfg(1, 15, 0, 0);
    cfg(1, 24, 0, 0);
    cfg(0, 17, 1, 256);
    cfg(0, 17, 5, 3);
    cfg(1, 17, 0, 0);
    // R3 write then read
    cfg(0, 17, 2, 5);
    cfg(1, 17, 0, 0);
    // R4 message edge unmasked
    pulse(1);
    expect_offer("R4 offer", 17, 2, 5);
    consume();
    chk("R4 consumed", 32'(pres_valid), 0);
    // R5 masked edge remembered
    pulse(0);
    chk("R5 masked no offer", 32'(pres_valid), 0);
    cfg(0, 16, 1, 3);
    expect_offer("R5 pending offer", 16, 1, 3);
    consume();
    // R6 level input
    cfg(0, 20, 3, 7);
    src_in[4] = 1;
    @(negedge clk);
    expect_offer("R6 level offer", 20, 3, 7);
    consume();
    cfg(0, 20, 3, 7);
    chk("R6 sent blocks re-offer", 32'(pres_valid), 0);
    // R8 eoi then re-evaluation
    eoi_valid = 1; eoi_num = 12'd20; @(negedge clk); eoi_valid = 0;
    chk("R8 eoi offers nothing", 32'(pres_valid), 0);
    cfg(0, 20, 3, 7);
    expect_offer("R8 re-offer after eoi", 20, 3, 7);
    consume();
    // R7 / R9 / R11 rejects and scan
    strobe_rej(20);
    strobe_rej(17);
    strobe_rej(18);
    resend_req = 1; @(negedge clk); resend_req = 0;
    chk("R11 busy after request", 32'(resend_busy), 1);
    chk("R11 no offer yet", 32'(pres_valid), 0);
    @(negedge clk);
    chk("R11 idx0 nothing", 32'(pres_valid), 0);
    @(negedge clk);
    expect_offer("R9 rejected message re-offered", 17, 2, 5);
    repeat (3) @(negedge clk);
    chk("R11 stalled busy", 32'(resend_busy), 1);
    chk("R11 stalled offer held", 32'(pres_num), 17);
    consume();
    chk("R11 after take", 32'(pres_valid), 0);
    @(negedge clk);
    chk("R9 masked rejected not offered", 32'(pres_valid), 0);
    @(negedge clk);
    chk("R11 idx3", 32'(pres_valid), 0);
    @(negedge clk);
    expect_offer("R7 level re-offered after reject", 20, 3, 7);
    consume();
    @(negedge clk);
    @(negedge clk);
    chk("R11 busy before last", 32'(resend_busy), 1);
    @(negedge clk);
    chk("R11 done after last", 32'(resend_busy), 0);
    cfg(0, 18, 0, 4);
    chk("R9 no pending on unmask", 32'(pres_valid), 0);
    resend_req = 1; @(negedge clk); resend_req = 0;
    seen = 0;
    repeat (12) begin if (pres_valid) seen = 1; @(negedge clk); end
    chk("R9 rejected bits were cleared", 32'(seen), 0);
    chk("R11 second scan done", 32'(resend_busy), 0);
    // R10 disable / enable
    cfg(2, 17, 0, 0);
    cfg(1, 17, 0, 0);
    pulse(1);
    chk("R10 disabled no offer", 32'(pres_valid), 0);
    cfg(3, 17, 0, 0);
    expect_offer("R10 enable restores", 17, 2, 5);
    consume();
    cfg(1, 17, 0, 0);
    // R12 write and edge same cycle
    cfg_valid = 1; cfg_op = 2'd0; cfg_num = 12'd19; cfg_srv = 3'd1; cfg_prio = 9'd6;
    src_in[3] = 1;
    @(negedge clk);
    cfg_valid = 0; src_in[3] = 0;
    sh_srv[3] = 1; sh_prio[3] = 6; sh_sav[3] = 6;
    expect_offer("R12 write first", 19, 1, 6);
    consume();
    // R13 lowest first
    src_in[1:0] = 2'b11;
    @(negedge clk);
    src_in[1:0] = 2'b00;
    expect_offer("R13 lowest first", 16, 1, 3);
    consume();
    expect_offer("R13 next", 17, 2, 5);
    consume();
    chk("R13 drained", 32'(pres_valid), 0);
    // random routing traffic, R2/R3/R10 against shadow
    pres_ready = 1;
    for (int n = 0; n < 60; n++)
      cfg(int'($urandom % 4), 14 + int'($urandom % 12), int'($urandom % 6), int'($urandom % 300));
    for (int k = 16; k < 24; k++) cfg(1, k, 0, 0);
    pres_ready = 0;
    summary();
  end
endmodule